// File: doc/BRIEF.md
# Vector Command Decoder with Undefined-Opcode Trap

This block takes 16-bit commands from a command list and sorts each one by its top five bits. Three opcodes load a vector pointer. For each of these the block fetches a 32-bit double-word through a 16-bit memory read port and writes it into one of three pointer registers. Opcodes that a parameter marks as arithmetic go to a separate execution unit through a start/done handshake, and the decoder waits for that unit to finish.

Every remaining opcode is undefined. An undefined opcode stops the command stream, sends a one-cycle non-maskable interrupt pulse and sets a sticky status flag. The decoder then accepts nothing more until a restart strobe arrives. The pointer registers are never touched by the trap or by arithmetic commands.

Top module: `vdsp_cmd_decoder`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the decoder is idle. Bits [15:11] are the opcode and bits [10:0] are a double-word address.
- R2: Opcodes 2, 3 and 4 load the fetched double-word into `ptr_x`, `ptr_y` and `ptr_z` respectively, and the other two pointer registers keep their values.
- R3: A load issues exactly two single-cycle reads: first at word address 2*addr, then at 2*addr+1. The first word returned forms bits [15:0] of the pointer and the second forms bits [31:16].
- R4: Load commands never pulse `exec_start`.
- R5: An opcode whose bit is set in `EXEC_OPS` (default: opcodes 5 to 15) raises `exec_start` for one cycle, with `exec_op` equal to the whole command. `cmd_ready` stays low until `exec_done` is seen.
- R6: Any other opcode (default: 0, 1 and 16 to 31) is undefined and has the following effects:
  - `nmi_pulse` is high for exactly one cycle.
  - `stat_undef` goes to 1.
  - No memory read is issued and no execution start is given.
  - The pointers are unchanged.
- R7: After an undefined opcode, `cmd_ready` stays low and offered commands have no effect until `restart` is pulsed.
- R8: `stat_undef` stays 1 until `stat_clr` is driven high for a cycle. Clearing it does not by itself resume command acceptance.
- R9: When no load or execution is pending, a `mem_rvalid` or `exec_done` pulse changes no pointer and does not drop `cmd_ready`.
- R10: After reset the following hold:
  - `cmd_ready` is 1.
  - The pointers are 0.
  - `exec_start`, `nmi_pulse`, `stat_undef` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_data | input | 16 | Command word |
| cmd_ready | output | 1 | Decoder can take a command |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 12 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| ptr_x | output | 32 | X vector pointer |
| ptr_y | output | 32 | Y vector pointer |
| ptr_z | output | 32 | Z vector pointer |
| exec_start | output | 1 | One-cycle start to the execution unit |
| exec_op | output | 16 | Command handed to the execution unit |
| exec_done | input | 1 | Execution unit finished |
| nmi_pulse | output | 1 | Non-maskable interrupt request pulse |
| stat_undef | output | 1 | Sticky undefined-opcode flag |
| stat_clr | input | 1 | Write-one-to-clear for the flag |
| restart | input | 1 | Leave the trapped state |

## Verification
The hardest situations to reach from the ports are the halted state and the arrival of handshake signals nobody asked for. In the halted state, a command that is held valid must be ignored. The stimulus first traps on undefined opcodes at both edges of the arithmetic range. It then holds a valid load command for several cycles and confirms that no read request appears. Separately, it forces unsolicited read-valid and done pulses into an idle decoder. This uses an injection path that is ORed onto the memory model's response.

// File: rtl/vdsp_dec_pkg.sv
package vdsp_dec_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_LDX = 5'd2;
  localparam logic [OPC_W-1:0] OPC_LDY = 5'd3;
  localparam logic [OPC_W-1:0] OPC_LDZ = 5'd4;

  typedef enum logic [1:0] {
    CK_RSVD = 2'd0,
    CK_LOAD = 2'd1,
    CK_EXEC = 2'd2
  } cmd_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_HALT  = 2'd3
  } dec_state_t;
endpackage

// File: rtl/vdsp_op_classify.sv
module vdsp_op_classify
  import vdsp_dec_pkg::*;
#(
  parameter int                  SEL_W    = 2,
  parameter logic [2**OPC_W-1:0] EXEC_OPS = 32'h0000_FFE0
) (
  input  logic [OPC_W-1:0] opc,
  output cmd_kind_t        kind,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    kind = CK_RSVD;
    sel  = '0;
    if (opc == OPC_LDX) begin
      kind = CK_LOAD;
      sel  = SEL_W'(0);
    end else if (opc == OPC_LDY) begin
      kind = CK_LOAD;
      sel  = SEL_W'(1);
    end else if (opc == OPC_LDZ) begin
      kind = CK_LOAD;
      sel  = SEL_W'(2);
    end else if (EXEC_OPS[opc]) begin
      kind = CK_EXEC;
    end
  end
endmodule

// File: rtl/vdsp_ptr_fetch.sv
module vdsp_ptr_fetch #(
  parameter int ADDR_W = 11,
  parameter int MEM_W  = 16,
  parameter int PTR_W  = 32,
  localparam int HALVES  = PTR_W / MEM_W,
  localparam int IDX_W   = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int MADDR_W = ADDR_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  dw_addr,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [MEM_W-1:0]   mem_rdata,
  output logic               done,
  output logic [PTR_W-1:0]   data
);
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      base     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      data     <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        base     <= dw_addr;
        idx      <= '0;
        mem_req  <= 1'b1;
        mem_addr <= {dw_addr, IDX_W'(0)};
      end else if (busy && mem_rvalid) begin
        // low half arrives first and ends up in the low bits after the shifts
        data <= {mem_rdata, data[PTR_W-1:MEM_W]};
        if (idx == IDX_W'(HALVES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx      <= idx + IDX_W'(1);
          mem_req  <= 1'b1;
          mem_addr <= {base, idx + IDX_W'(1)};
        end
      end
    end
  end
endmodule

// File: rtl/vdsp_ptr_bank.sv
module vdsp_ptr_bank #(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 32,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [PTR_W-1:0]               wr_data,
  output logic [NUM_PTR-1:0][PTR_W-1:0]  ptrs
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        ptrs[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))
        ptrs[g] <= wr_data;
    end
  end
endmodule

// File: rtl/vdsp_cmd_decoder.sv
module vdsp_cmd_decoder
  import vdsp_dec_pkg::*;
#(
  parameter int                  CMD_W    = 16,
  parameter int                  MEM_W    = 16,
  parameter int                  PTR_W    = 32,
  parameter logic [2**OPC_W-1:0] EXEC_OPS = 32'h0000_FFE0,
  localparam int ADDR_W  = CMD_W - OPC_W,
  localparam int HALVES  = PTR_W / MEM_W,
  localparam int IDX_W   = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int MADDR_W = ADDR_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic               cmd_ready,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [MEM_W-1:0]   mem_rdata,
  output logic [PTR_W-1:0]   ptr_x,
  output logic [PTR_W-1:0]   ptr_y,
  output logic [PTR_W-1:0]   ptr_z,
  output logic               exec_start,
  output logic [CMD_W-1:0]   exec_op,
  input  logic               exec_done,
  output logic               nmi_pulse,
  output logic               stat_undef,
  input  logic               stat_clr,
  input  logic               restart
);
  localparam int NUM_PTR = 3;
  localparam int SEL_W   = $clog2(NUM_PTR);

  dec_state_t  state;
  cmd_kind_t   kind;
  logic [SEL_W-1:0] sel, tgt;
  logic             take, fetch_done;
  logic [PTR_W-1:0] fetch_data;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;

  assign cmd_ready = (state == ST_IDLE);
  assign take      = cmd_valid && cmd_ready;

  vdsp_op_classify #(.SEL_W(SEL_W), .EXEC_OPS(EXEC_OPS)) classify_i (
    .opc  (cmd_data[CMD_W-1 -: OPC_W]),
    .kind (kind),
    .sel  (sel)
  );

  vdsp_ptr_fetch #(.ADDR_W(ADDR_W), .MEM_W(MEM_W), .PTR_W(PTR_W)) fetch_i (
    .clk        (clk),
    .rst        (rst),
    .start      (take && kind == CK_LOAD),
    .dw_addr    (cmd_data[ADDR_W-1:0]),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (fetch_done),
    .data       (fetch_data)
  );

  vdsp_ptr_bank #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fetch_done),
    .wr_sel  (tgt),
    .wr_data (fetch_data),
    .ptrs    (ptrs)
  );

  assign ptr_x = ptrs[0];
  assign ptr_y = ptrs[1];
  assign ptr_z = ptrs[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tgt        <= '0;
      exec_start <= 1'b0;
      exec_op    <= '0;
      nmi_pulse  <= 1'b0;
      stat_undef <= 1'b0;
    end else begin
      exec_start <= 1'b0;
      nmi_pulse  <= 1'b0;
      if (stat_clr)
        stat_undef <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            unique case (kind)
              CK_LOAD: begin
                tgt   <= sel;
                state <= ST_FETCH;
              end
              CK_EXEC: begin
                exec_start <= 1'b1;
                exec_op    <= cmd_data;
                state      <= ST_EXEC;
              end
              default: begin
                nmi_pulse  <= 1'b1;
                stat_undef <= 1'b1;
                state      <= ST_HALT;
              end
            endcase
          end
        end
        ST_FETCH: if (fetch_done) state <= ST_IDLE;
        ST_EXEC:  if (exec_done)  state <= ST_IDLE;
        default:  if (restart)    state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vdsp_cmd_decoder_chk.sv
module vdsp_cmd_decoder_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic mem_req,
  input logic exec_start,
  input logic nmi_pulse,
  input logic stat_undef,
  input logic stat_clr
);
  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);
  // R6
  nmi_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |-> stat_undef);
  // R7
  halt_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |-> !cmd_ready);
  // R5
  exec_single_chk: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);
  // R5
  exec_busy_chk: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> !cmd_ready);
  // R3
  read_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_undef && !stat_clr) |=> stat_undef);
endmodule

bind vdsp_cmd_decoder vdsp_cmd_decoder_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .mem_req    (mem_req),
  .exec_start (exec_start),
  .nmi_pulse  (nmi_pulse),
  .stat_undef (stat_undef),
  .stat_clr   (stat_clr)
);

// File: tb/vdsp_cmd_decoder_tb_top.sv
module vdsp_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        model_rv;
  logic        inj_rv = 1'b0;
  logic [15:0] mem_rdata;
  logic [31:0] ptr_x, ptr_y, ptr_z;
  logic        exec_start;
  logic [15:0] exec_op;
  logic        exec_done = 1'b0;
  logic        nmi_pulse, stat_undef;
  logic        stat_clr = 1'b0;
  logic        restart = 1'b0;

  int tests = 0;
  int fails = 0;
  int nmi_cnt = 0, exec_cnt = 0, req_n = 0;
  logic [11:0] req_log [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  vdsp_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(model_rv | inj_rv), .mem_rdata(mem_rdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .exec_start(exec_start), .exec_op(exec_op), .exec_done(exec_done),
    .nmi_pulse(nmi_pulse), .stat_undef(stat_undef),
    .stat_clr(stat_clr), .restart(restart)
  );

  // memory model: two-cycle read latency, data = {4'hC, word address}
  logic        rq_d1;
  logic [11:0] ad_d1;
  always @(posedge clk) begin
    if (rst) begin
      rq_d1 <= 1'b0; ad_d1 <= '0; model_rv <= 1'b0; mem_rdata <= '0;
    end else begin
      rq_d1     <= mem_req;
      ad_d1     <= mem_addr;
      model_rv  <= rq_d1;
      mem_rdata <= {4'hC, ad_d1};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (nmi_pulse)  nmi_cnt++;
      if (exec_start) exec_cnt++;
      if (mem_req) begin
        req_log[req_n % 16] = mem_addr;
        req_n++;
      end
    end
  end

  function automatic logic [31:0] exp_ptr(input logic [10:0] a);
    return {4'hC, a, 1'b1, 4'hC, a, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [15:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50 && !cmd_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready", 32'(cmd_ready), 32'd1);
    chk("R10 ptrs", ptr_x | ptr_y | ptr_z, 32'd0);
    chk("R10 pulses", 32'({exec_start, nmi_pulse, stat_undef, mem_req}), 32'd0);
  endtask

  task automatic t_load(input logic [4:0] opc, input logic [10:0] a, input int which);
    logic [31:0] bx, by, bz;
    int r0, e0;
    bx = ptr_x; by = ptr_y; bz = ptr_z; r0 = req_n; e0 = exec_cnt;
    send_cmd({opc, a});
    wait_ready();
    chk("R1 ready after load", 32'(cmd_ready), 32'd1);
    chk("R3 read count", 32'(req_n - r0), 32'd2);
    chk("R3 low word addr", 32'(req_log[r0 % 16]), 32'({a, 1'b0}));
    chk("R3 high word addr", 32'(req_log[(r0 + 1) % 16]), 32'({a, 1'b1}));
    chk("R2 x", ptr_x, (which == 0) ? exp_ptr(a) : bx);
    chk("R2 y", ptr_y, (which == 1) ? exp_ptr(a) : by);
    chk("R2 z", ptr_z, (which == 2) ? exp_ptr(a) : bz);
    chk("R4 no exec on load", 32'(exec_cnt - e0), 32'd0);
  endtask

  task automatic t_exec(input logic [4:0] opc, input logic [10:0] a);
    int r0, e0;
    r0 = req_n; e0 = exec_cnt;
    send_cmd({opc, a});
    chk("R5 exec_start", 32'(exec_start), 32'd1);
    chk("R5 exec_op", 32'(exec_op), 32'({opc, a}));
    repeat (4) begin
      @(negedge clk);
      chk("R5 wait for done", 32'(cmd_ready), 32'd0);
    end
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk("R5 ready after done", 32'(cmd_ready), 32'd1);
    chk("R5 one start", 32'(exec_cnt - e0), 32'd1);
    chk("R5 no reads", 32'(req_n - r0), 32'd0);
  endtask

  task automatic t_trap(input logic [4:0] opc);
    logic [31:0] bx, by, bz;
    int r0, e0, n0;
    bx = ptr_x; by = ptr_y; bz = ptr_z; r0 = req_n; e0 = exec_cnt; n0 = nmi_cnt;
    send_cmd({opc, 11'h2AB});
    chk("R6 nmi high", 32'(nmi_pulse), 32'd1);
    chk("R6 flag set", 32'(stat_undef), 32'd1);
    // R7: a load held valid while halted is not taken
    cmd_valid = 1'b1;
    cmd_data  = {5'd2, 11'h011};
    repeat (6) begin
      @(negedge clk);
      chk("R7 halted", 32'(cmd_ready), 32'd0);
    end
    cmd_valid = 1'b0;
    chk("R6 one nmi", 32'(nmi_cnt - n0), 32'd1);
    chk("R6 no reads", 32'(req_n - r0), 32'd0);
    chk("R6 no exec", 32'(exec_cnt - e0), 32'd0);
    chk("R6 ptrs kept", ptr_x ^ bx | ptr_y ^ by | ptr_z ^ bz, 32'd0);
    chk("R8 sticky", 32'(stat_undef), 32'd1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R8 cleared", 32'(stat_undef), 32'd0);
    chk("R8 still halted", 32'(cmd_ready), 32'd0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R7 restart", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_stray();
    logic [31:0] bx, by, bz;
    int e0;
    bx = ptr_x; by = ptr_y; bz = ptr_z; e0 = exec_cnt;
    @(negedge clk);
    inj_rv = 1'b1; exec_done = 1'b1;
    @(negedge clk);
    inj_rv = 1'b0; exec_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ready kept", 32'(cmd_ready), 32'd1);
    chk("R9 ptrs kept", ptr_x ^ bx | ptr_y ^ by | ptr_z ^ bz, 32'd0);
    chk("R9 no exec", 32'(exec_cnt - e0), 32'd0);
  endtask

  initial begin
    t_reset();
    t_load(5'd2, 11'h123, 0);
    t_load(5'd3, 11'h7FF, 1);
    t_load(5'd4, 11'h000, 2);
    t_load(5'd2, 11'h555, 0);
    t_exec(5'd5, 11'h00F);
    t_exec(5'd15, 11'h7F0);
    t_trap(5'd0);
    t_trap(5'd16);
    t_trap(5'd31);
    t_trap(5'd1);
    t_stray();
    t_load(5'd3, 11'h0A5, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule